// File: doc/BRIEF.md
# Serial host control/status register

This block holds the 24-bit control/status word of a serial host port that can run either as SPI or as I2C. Software writes three control bits (enable, protocol select, master select) through a simple write strobe and reads the whole word back on a combinational read bus. The transfer engine reports a live busy level and single-cycle event pulses, which the block keeps as sticky status flags.

Clearing the enable bit puts the port into an individual reset one clock later. While it lasts, the pin inputs are inhibited, the pin drivers are released to high impedance, the status flags are held at their reset value, and the transfer engine is held in reset. The control bits are not touched, so software can change the protocol or the role while the port is idle. A sticky protocol-error flag records that the enable bit was cleared while a master transfer was still busy. Only a hardware reset or a software reset clears this flag.

Top module: `shost_csr`

## Requirements
- R1: Bit 0 of the register is the enable bit. A write sets it to wr_data_i[0], `ctl_en_o` shows the new value from the clock edge that takes the write, and a read returns it in bit 0.
- R2: Bit 1 selects the protocol (0 = SPI, 1 = I2C). It is written from wr_data_i[1], driven on `ctl_i2c_o`, and read back in bit 1.
- R3: Bit 2 selects master mode (1 = master). It is written from wr_data_i[2], driven on `ctl_master_o`, and read back in bit 2.
- R4: `indiv_rst_o` follows the inverse of the enable bit with exactly one clock of delay, both on entry to and on exit from individual reset.
- R5: While `indiv_rst_o` is 1, `in_inhibit_o` is 1 and `pin_oe_o` is 0. Otherwise `in_inhibit_o` is 0 and `pin_oe_o` is 1.
- R6: Read bits 11:8 are sticky event flags. A 1 on stat_set_i[k] at a clock edge sets flag k. At any clock edge where `indiv_rst_o` or `stop_i` is 1, all flags clear, and the clear wins over a set in the same cycle.
- R7: Read bit 12 shows `busy_i` in the same cycle, and reads 0 while `indiv_rst_o` is 1.
- R8: Read bit 13 is a protocol-error flag. It is set by a write with wr_data_i[0]=0 while the enable bit, the master bit and `busy_i` are all 1. It stays set through individual reset and stop, and is cleared only by hardware or software reset.
- R9: After `rst_n` is low or `sw_rst_i` is high at a clock edge, all control bits, flags and the error flag are 0 and `indiv_rst_o` is 1. A software reset takes priority over a write in the same cycle.
- R10: Writes to bits 23:3 have no effect, and read bits 23:14 and 7:3 are always 0.
- R11: The control bits keep their values through individual reset and through `stop_i`. Only a write or a reset changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst_i | input | 1 | Synchronous software reset, active high |
| stop_i | input | 1 | Stop state; clears the status flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 24 | Register write data |
| rd_data_o | output | 24 | Register read data (combinational) |
| busy_i | input | 1 | Busy level from the transfer engine |
| stat_set_i | input | 4 | Event pulses that set the sticky flags |
| ctl_en_o | output | 1 | Enable control bit |
| ctl_i2c_o | output | 1 | Protocol select (1 = I2C) |
| ctl_master_o | output | 1 | Master mode select |
| indiv_rst_o | output | 1 | Individual reset to the transfer engine |
| in_inhibit_o | output | 1 | Pin input inhibit |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
Control bits, the sticky flags and the error flag update at the clock edge that takes the write or the event. Individual reset and the pin controls follow one further edge later. The busy read bit is combinational and is due in the same cycle. The bench drives inputs and compares every output on the falling edge. At each falling edge it first compares against a reference model advanced by one edge, and only then applies new inputs, so each result is checked at the cycle where it is due. Directed sequences cover a master write that drops the enable bit while busy, a flag set that collides with a clear, and a software reset that collides with a write.

// File: rtl/shost_pkg.sv
// Shared constants and types for the serial host control/status register.
// Assumes a fixed three-bit control field at the bottom of the word.
package shost_pkg;
    localparam int CTRL_W  = 3;
    localparam int EN_POS  = 0;
    localparam int I2C_POS = 1;
    localparam int MS_POS  = 2;

    typedef struct packed {
        logic master;
        logic i2c;
        logic en;
    } ctrl_t;

    // Extract the control field from a write word.
    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.en     = w[EN_POS];
        c.i2c    = w[I2C_POS];
        c.master = w[MS_POS];
        return c;
    endfunction
endpackage

// File: rtl/shost_ctrl_regs.sv
// Control bit storage and sticky protocol-error flag.
// Assumes the write strobe is a single-cycle qualified pulse; software reset
// outranks a write in the same cycle. The error flag ignores individual reset.
module shost_ctrl_regs
    import shost_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_ctrl_i,
    input  logic              busy_i,
    output ctrl_t             ctrl_o,
    output logic              perr_o
);
    ctrl_t ctrl_q;
    logic  perr_q;
    logic  bad_disable;

    // Flag a disable that lands while a master transfer is still busy.
    always_comb begin
        bad_disable = wr_en_i && !wr_ctrl_i[EN_POS] && ctrl_q.en && ctrl_q.master && busy_i;
    end

    // Control bits: cleared by either reset, otherwise loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            ctrl_q <= '0;
        end else if (wr_en_i) begin
            ctrl_q <= ctrl_from_word(wr_ctrl_i);
        end
    end

    // Error flag: sticky until a hardware or software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            perr_q <= 1'b0;
        end else if (bad_disable) begin
            perr_q <= 1'b1;
        end
    end

    assign ctrl_o = ctrl_q;
    assign perr_o = perr_q;
endmodule

// File: rtl/shost_irst_seq.sv
// Individual reset sequencer: delays the inverse of the enable bit by one
// clock and derives the pin controls from it. Assumes enable is registered.
module shost_irst_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst_i,
    input  logic en_i,
    output logic irst_o,
    output logic inhibit_o,
    output logic oe_o
);
    logic irst_q;

    // One-cycle delayed individual reset; held active by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            irst_q <= 1'b1;
        end else begin
            irst_q <= !en_i;
        end
    end

    // Pin control decode from the individual reset state.
    always_comb begin
        inhibit_o = irst_q;
        oe_o      = !irst_q;
    end

    assign irst_o = irst_q;
endmodule

// File: rtl/shost_status.sv
// Sticky event flags fed by pulses from the transfer engine.
// Assumes a clear request (individual reset or stop) outranks a set.
module shost_status #(
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              clr_i,
    input  logic [STAT_W-1:0] set_i,
    output logic [STAT_W-1:0] flags_o
);
    logic [STAT_W-1:0] flag_q;

    for (genvar k = 0; k < STAT_W; k++) begin : g_flag
        // One sticky bit per event line.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst_i || clr_i) begin
                flag_q[k] <= 1'b0;
            end else if (set_i[k]) begin
                flag_q[k] <= 1'b1;
            end
        end
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/shost_csr.sv
// Serial host control/status register top. Holds the control bits, runs the
// individual reset sequence, keeps the sticky status and builds the read word.
// Assumes DATA_W is wide enough for every field (checked at elaboration).
module shost_csr
    import shost_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              busy_i,
    input  logic [STAT_W-1:0] stat_set_i,
    output logic              ctl_en_o,
    output logic              ctl_i2c_o,
    output logic              ctl_master_o,
    output logic              indiv_rst_o,
    output logic              in_inhibit_o,
    output logic              pin_oe_o
);
    localparam int FLAG_LSB = 8;
    localparam int BUSY_POS = FLAG_LSB + STAT_W;
    localparam int PERR_POS = BUSY_POS + 1;

    if (PERR_POS >= DATA_W) begin : g_width_err
        $error("shost_csr: DATA_W too small for the status fields");
    end

    ctrl_t             ctrl;
    logic              perr;
    logic              irst;
    logic [STAT_W-1:0] flags;

    shost_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst_i  (sw_rst_i),
        .wr_en_i   (wr_en_i),
        .wr_ctrl_i (wr_data_i[CTRL_W-1:0]),
        .busy_i    (busy_i),
        .ctrl_o    (ctrl),
        .perr_o    (perr)
    );

    shost_irst_seq u_irst (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst_i  (sw_rst_i),
        .en_i      (ctrl.en),
        .irst_o    (irst),
        .inhibit_o (in_inhibit_o),
        .oe_o      (pin_oe_o)
    );

    shost_status #(.STAT_W(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst_i (sw_rst_i),
        .clr_i    (irst || stop_i),
        .set_i    (stat_set_i),
        .flags_o  (flags)
    );

    // Read word assembly; unused positions stay zero.
    always_comb begin
        rd_data_o                             = '0;
        rd_data_o[EN_POS]                     = ctrl.en;
        rd_data_o[I2C_POS]                    = ctrl.i2c;
        rd_data_o[MS_POS]                     = ctrl.master;
        rd_data_o[FLAG_LSB +: STAT_W]         = flags;
        rd_data_o[BUSY_POS]                   = busy_i && !irst;
        rd_data_o[PERR_POS]                   = perr;
    end

    assign ctl_en_o     = ctrl.en;
    assign ctl_i2c_o    = ctrl.i2c;
    assign ctl_master_o = ctrl.master;
    assign indiv_rst_o  = irst;
endmodule

// File: rtl/shost_csr_chk.sv
// Assertion checker for shost_csr, attached by bind. Observes ports only.
module shost_csr_chk #(
    parameter int DATA_W = 24,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst_i,
    input logic              stop_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              busy_i,
    input logic              ctl_en_o,
    input logic              ctl_i2c_o,
    input logic              ctl_master_o,
    input logic              indiv_rst_o,
    input logic              in_inhibit_o,
    input logic              pin_oe_o
);
    localparam int FLAG_LSB = 8;
    localparam int BUSY_POS = FLAG_LSB + STAT_W;
    localparam int PERR_POS = BUSY_POS + 1;

    // R4
    irst_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst_i |=> (indiv_rst_o == !$past(ctl_en_o)));

    // R5
    pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        indiv_rst_o |-> (in_inhibit_o && !pin_oe_o));

    // R7
    busy_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        indiv_rst_o |-> !rd_data_o[BUSY_POS]);

    // R8
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[PERR_POS] && !sw_rst_i) |=> rd_data_o[PERR_POS]);

    // R8
    perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[0] && ctl_en_o && ctl_master_o && busy_i && !sw_rst_i)
        |=> rd_data_o[PERR_POS]);

    // R11
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !sw_rst_i) |=> ($stable(ctl_en_o) && $stable(ctl_i2c_o) && $stable(ctl_master_o)));

    // R6
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (indiv_rst_o || stop_i) |=> (rd_data_o[FLAG_LSB +: STAT_W] == '0));
endmodule

bind shost_csr shost_csr_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_rst_i     (sw_rst_i),
    .stop_i       (stop_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .busy_i       (busy_i),
    .ctl_en_o     (ctl_en_o),
    .ctl_i2c_o    (ctl_i2c_o),
    .ctl_master_o (ctl_master_o),
    .indiv_rst_o  (indiv_rst_o),
    .in_inhibit_o (in_inhibit_o),
    .pin_oe_o     (pin_oe_o)
);

// File: tb/tb_shost_csr.sv
// Bench for shost_csr: seeded random stimulus plus directed corners,
// compared against a cycle model kept in the bench.
module tb_shost_csr;
    localparam int DW = 24;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n, sw_rst, stop, wr_en, busy;
    logic [DW-1:0] wr_data;
    logic [SW-1:0] stat_set;
    logic [DW-1:0] rd_data;
    logic          c_en, c_i2c, c_ms, irst, inhib, oe;

    int total = 0;
    int bad   = 0;

    // model state
    logic          m_en, m_i2c, m_ms, m_perr, m_irst;
    logic [SW-1:0] m_flags;

    always #10 clk = ~clk;

    shost_csr dut (
        .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst), .stop_i(stop),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .busy_i(busy), .stat_set_i(stat_set),
        .ctl_en_o(c_en), .ctl_i2c_o(c_i2c), .ctl_master_o(c_ms),
        .indiv_rst_o(irst), .in_inhibit_o(inhib), .pin_oe_o(oe)
    );

    function automatic logic [DW-1:0] exp_word();
        logic [DW-1:0] w = '0;
        w[0] = m_en; w[1] = m_i2c; w[2] = m_ms;
        w[11:8] = m_flags;
        w[12] = busy && !m_irst;
        w[13] = m_perr;
        return w;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1", DW'(c_en), DW'(m_en));
        chk("R2", DW'(c_i2c), DW'(m_i2c));
        chk("R3", DW'(c_ms), DW'(m_ms));
        chk("R4", DW'(irst), DW'(m_irst));
        chk("R5", DW'({inhib, oe}), DW'({m_irst, !m_irst}));
        chk("R10_word", rd_data, exp_word());
    endtask

    // Advance the model by one clock edge from the inputs now applied.
    task automatic model_step();
        if (!rst_n || sw_rst) begin
            m_en = 0; m_i2c = 0; m_ms = 0; m_perr = 0; m_flags = '0; m_irst = 1;
        end else begin
            logic old_en = m_en;
            if (wr_en && !wr_data[0] && m_en && m_ms && busy) m_perr = 1;
            m_flags = (m_irst || stop) ? '0 : (m_flags | stat_set);
            m_irst = !old_en;
            if (wr_en) begin
                m_en = wr_data[0]; m_i2c = wr_data[1]; m_ms = wr_data[2];
            end
        end
    endtask

    // Apply inputs (just after a falling edge), step one clock, then compare.
    task automatic cyc(input logic r, input logic s, input logic st, input logic w,
                       input logic [DW-1:0] d, input logic b, input logic [SW-1:0] ev);
        rst_n = r; sw_rst = s; stop = st; wr_en = w; wr_data = d; busy = b; stat_set = ev;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input logic b);
        cyc(1, 0, 0, 0, '0, b, '0);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5ead_c0de));
        rst_n = 0; sw_rst = 0; stop = 0; wr_en = 0; wr_data = '0; busy = 0; stat_set = '0;
        m_en = 0; m_i2c = 0; m_ms = 0; m_perr = 0; m_flags = '0; m_irst = 1;
        @(negedge clk);
        // R9 reset state
        cyc(0, 0, 0, 0, '0, 0, '0);
        cyc(0, 0, 0, 0, '0, 0, '0);
        chk("R9_rst", rd_data, 24'h0);
        chk("R9_irst", DW'(irst), 24'h1);

        // R10: write all ones, only bits 2:0 land
        cyc(1, 0, 0, 1, 24'hFFFFFF, 0, '0);
        chk("R10_mask", rd_data & 24'hFFC0F8, 24'h0);
        // R4: reset releases one edge later
        chk("R4_pre", DW'(irst), 24'h1);
        idle(1);
        chk("R4_post", DW'(irst), 24'h0);
        chk("R7_busy", DW'(rd_data[12]), 24'h1);

        // R6: flag set, then collision of set with stop
        cyc(1, 0, 0, 0, '0, 0, 4'b0101);
        chk("R6_set", DW'(rd_data[11:8]), 24'h5);
        cyc(1, 0, 1, 0, '0, 0, 4'b1010);
        chk("R6_clr", DW'(rd_data[11:8]), 24'h0);

        // R8: disable while master and busy
        cyc(1, 0, 0, 1, 24'h000006, 1, '0);
        chk("R8_set", DW'(rd_data[13]), 24'h1);
        chk("R11_keep", DW'({c_ms, c_i2c}), 24'h3);
        idle(0); idle(0);
        chk("R8_hold", DW'(rd_data[13]), 24'h1);
        chk("R5_idle", DW'({inhib, oe}), 24'h2);

        // R9: software reset beats a write
        cyc(1, 1, 0, 1, 24'h000007, 0, '0);
        chk("R9_sw", rd_data, 24'h0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic r  = ($urandom_range(0, 199) != 0);
            logic s  = ($urandom_range(0, 99) == 0);
            logic st = ($urandom_range(0, 15) == 0);
            logic w  = ($urandom_range(0, 3) == 0);
            logic [DW-1:0] d = $urandom();
            logic b  = ($urandom_range(0, 2) != 0);
            logic [SW-1:0] ev = ($urandom_range(0, 2) == 0) ? SW'($urandom()) : '0;
            if ($urandom_range(0, 1) == 1) d[2] = 1'b1;
            cyc(r, s, st, w, d, b, ev);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule